// File: doc/BRIEF.md
# Dual-History Top-Two Path Predictor

This block predicts which of the two most frequent paths through a loop body will run next. Each of the two paths has its own shift register of recent outcomes and its own table of saturating counters. At every cycle, each history selects one counter from its own table, and the larger of the two selected counts picks the predicted path. Equal counts favour path #1. No fixed threshold is involved.

When an iteration resolves, the caller presents a two-bit outcome code on the update port. The code moves a new bit into both histories. It also raises or lowers the two counters that the histories select at that moment. The lookup is a combinational read of registered state. A lookup made in the same cycle as an update therefore sees the state from before that update.

Top module: `dual_path_predictor`

## Requirements
- R1: While rst_ni is low, and right after it is released, both histories and every counter in both tables are zero. The outputs read pred_p2_o=0, cnt_p1_o=0 and cnt_p2_o=0.
- R2: On an accepted update, the path #1 history shifts left by one bit. Its new least significant bit is 1 when the outcome code is 01 (path #1) and 0 for any other accepted code.
- R3: On an accepted update, the path #2 history shifts left by one bit. Its new least significant bit is 1 when the outcome code is 10 (path #2) and 0 for any other accepted code.
- R4: cnt_p1_o is the path #1 table entry indexed by the path #1 history. cnt_p2_o is the path #2 table entry indexed by the path #2 history.
- R5: Outcome code 01 increments the path #1 counter selected by the path #1 history. It decrements the path #2 counter selected by the path #2 history.
- R6: Outcome code 10 increments the selected path #2 counter and decrements the selected path #1 counter.
- R7: Outcome code 00 (another path) decrements both selected counters.
- R8: Counters saturate. An increment at 2^CNT_W-1 leaves the value there, and a decrement at 0 leaves it at 0.
- R9: pred_p2_o is 1 (predict path #2) only when cnt_p2_o > cnt_p1_o. Otherwise it is 0 (predict path #1), and this includes equal counts.
- R10: Outcome code 11, or upd_valid_i low, changes neither history nor any counter.
- R11: While an update is presented, the outputs reflect the state before that update. The update becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_valid_i | input | 1 | An outcome is presented this cycle |
| upd_path_i | input | 2 | Outcome code: 00 other, 01 path #1, 10 path #2, 11 ignored |
| pred_p2_o | output | 1 | 1 = predict path #2, 0 = predict path #1 |
| cnt_p1_o | output | CNT_W | Path #1 count selected by the path #1 history |
| cnt_p2_o | output | CNT_W | Path #2 count selected by the path #2 history |

## Verification
A corrupted history bit selects a different counter. It becomes visible on cnt_p1_o or cnt_p2_o in the cycle after the faulty shift, and it persists for up to HIST_W further updates until the bad bit leaves the register. A wrong increment, decrement or saturation step shows only when that table entry is selected again, which can take several updates. For this reason the bench compares both counts and the prediction against an independent model after every update, and also during every update.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  typedef enum logic [1:0] {
    PATH_OTHER = 2'b00,
    PATH_ONE   = 2'b01,
    PATH_TWO   = 2'b10,
    PATH_NONE  = 2'b11
  } path_e;
endpackage

// File: rtl/dpp_history.sv
module dpp_history #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] hist_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= {hist_q[W-2:0], bit_i};
  end

  assign hist_o = hist_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hist_q));
endmodule

// File: rtl/dpp_table.sv
module dpp_table #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [DEPTH-1:0][CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rd_cnt, nxt_cnt;

  assign rd_cnt = cnt_q[idx_i];

  always_comb begin
    if (inc_i) nxt_cnt = (rd_cnt == CMAX) ? rd_cnt : rd_cnt + 1'b1;
    else       nxt_cnt = (rd_cnt == '0)   ? rd_cnt : rd_cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q[idx_i] <= nxt_cnt;
  end

  assign cnt_o = rd_cnt;

  p_sat_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i && rd_cnt == CMAX) |=> cnt_q[$past(idx_i)] == CMAX);
  p_sat_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !inc_i && rd_cnt == '0) |=> cnt_q[$past(idx_i)] == '0);
  p_table_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/dpp_compare.sv
module dpp_compare #(
  parameter int unsigned CNT_W = 3
) (
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  output logic             pick_b_o
);
  // ties go to a
  assign pick_b_o = cnt_b_i > cnt_a_i;
endmodule

// File: rtl/dual_path_predictor.sv
module dual_path_predictor
  import dpp_pkg::*;
#(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  logic [1:0]       upd_path_i,
  output logic             pred_p2_o,
  output logic [CNT_W-1:0] cnt_p1_o,
  output logic [CNT_W-1:0] cnt_p2_o
);
  localparam int unsigned LANES = 2;

  path_e upd_path;
  logic  upd_en;
  logic [LANES-1:0][HIST_W-1:0] hist;
  logic [LANES-1:0][CNT_W-1:0]  cnt;

  assign upd_path = path_e'(upd_path_i);
  assign upd_en   = upd_valid_i && (upd_path != PATH_NONE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (upd_path == ((g == 0) ? PATH_ONE : PATH_TWO));

    dpp_history #(.W(HIST_W)) u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (upd_en),
      .bit_i  (hit),
      .hist_o (hist[g])
    );

    dpp_table #(.IDX_W(HIST_W), .CNT_W(CNT_W)) u_tab (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (upd_en),
      .inc_i  (hit),
      .idx_i  (hist[g]),
      .cnt_o  (cnt[g])
    );
  end

  dpp_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_a_i  (cnt[0]),
    .cnt_b_i  (cnt[1]),
    .pick_b_o (pred_p2_o)
  );

  assign cnt_p1_o = cnt[0];
  assign cnt_p2_o = cnt[1];

  p_p1_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_path_i == 2'b01) |=> (hist[0][0] && !hist[1][0]));
  p_p2_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_path_i == 2'b10) |=> (!hist[0][0] && hist[1][0]));
  p_other_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_path_i == 2'b00) |=> (!hist[0][0] && !hist[1][0]));
  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en |=> ($stable(cnt_p1_o) && $stable(cnt_p2_o)));
  p_pred_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_p1_o == cnt_p2_o) |-> !pred_p2_o);
endmodule

// File: tb/dual_path_predictor_test.sv
`timescale 1ns/1ps
module dual_path_predictor_test;
  localparam int HW = 4;
  localparam int CW = 3;
  localparam int DEPTH = 1 << HW;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NVEC = 24;
  // {valid, code}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b101, 3'b101, 3'b110, 3'b101, 3'b100, 3'b110, 3'b110, 3'b111,
    3'b101, 3'b001, 3'b110, 3'b101, 3'b101, 3'b100, 3'b110, 3'b101,
    3'b011, 3'b110, 3'b110, 3'b101, 3'b100, 3'b111, 3'b101, 3'b110
  };

  logic clk = 1'b0, rst_n = 1'b0, upd_valid = 1'b0;
  logic [1:0] upd_path = 2'b00;
  logic pred_p2;
  logic [CW-1:0] cnt_p1, cnt_p2;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_t1 [DEPTH], m_t2 [DEPTH];
  int m_h1, m_h2;

  always #2.5 clk = ~clk;

  dual_path_predictor #(.HIST_W(HW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .upd_path_i(upd_path),
    .pred_p2_o(pred_p2), .cnt_p1_o(cnt_p1), .cnt_p2_o(cnt_p2)
  );

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_t1[i] = 0; m_t2[i] = 0; end
    m_h1 = 0; m_h2 = 0;
  endtask

  function automatic int sat(int v, bit up);
    if (up) return (v == CMAX) ? v : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_update(bit v, logic [1:0] c);
    if (v && c != 2'b11) begin
      m_t1[m_h1] = sat(m_t1[m_h1], c == 2'b01);
      m_t2[m_h2] = sat(m_t2[m_h2], c == 2'b10);
      m_h1 = ((m_h1 << 1) | int'(c == 2'b01)) & (DEPTH - 1);
      m_h2 = ((m_h2 << 1) | int'(c == 2'b10)) & (DEPTH - 1);
    end
  endtask

  task automatic check(string req, int e_pred, int e1, int e2);
    n_chk++;
    if (pred_p2 !== e_pred[0] || cnt_p1 !== e1[CW-1:0] || cnt_p2 !== e2[CW-1:0]) begin
      n_bad++;
      $display("FAIL %s: got pred=%0d c1=%0d c2=%0d, expected pred=%0d c1=%0d c2=%0d",
               req, pred_p2, cnt_p1, cnt_p2, e_pred, e1, e2);
    end
  endtask

  task automatic check_model(string req);
    int a, b;
    a = m_t1[m_h1]; b = m_t2[m_h2];
    check(req, int'(b > a), a, b);
  endtask

  // called at a negedge with no update pending
  task automatic step(bit v, logic [1:0] c, string req);
    upd_valid = v; upd_path = c;
    #1 check_model({req, "/R11 pre"});
    @(posedge clk);
    model_update(v, c);
    @(negedge clk);
    upd_valid = 1'b0; upd_path = 2'b00;
    check_model(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; model_reset();
    #1 check("R1 in reset", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1 after reset", 0, 0, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 initial", 0, 0, 0);

    // mixed pattern against model (R2 R3 R4 R5 R6 R7 R9 R10)
    for (int i = 0; i < NVEC; i++) step(VEC[i][2], VEC[i][1:0], "R4 vector");

    // R8 ceiling on path #1
    do_reset();
    for (int i = 0; i < 12; i++) step(1'b1, 2'b01, "R5 path1 run");
    check("R8 ceiling", 0, CMAX, 0);

    // R7/R8 floor
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 2'b00, "R7 other run");
    check("R8 floor", 0, 0, 0);

    // R6/R9 path #2 dominance
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 2'b10, "R6 path2 run");
    check("R9 predict path2", 1, 0, 4);
    step(1'b1, 2'b11, "R10 code 11");
    check("R10 code 11 no change", 1, 0, 4);
    step(1'b0, 2'b01, "R10 valid low");
    check("R10 valid low no change", 1, 0, 4);
    step(1'b1, 2'b01, "R5 after path2");
    step(1'b1, 2'b00, "R7 after path2");
    step(1'b1, 2'b10, "R3 after other");

    // R1 mid-run reset
    do_reset();
    step(1'b1, 2'b01, "R2 after reset");
    check("R9 tie at zero", 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule